// File: doc/BRIEF.md
# Partitioned Fixed-Point Multiply Unit

This block is a SIMD multiplier for pixel arithmetic. It takes two 64-bit operands, `a_i` and `b_i`, and a 3-bit mode. It multiplies 8-bit values taken from `a_i` by signed 16-bit factors taken from `b_i` across four 16-bit lanes. Each lane result is rounded and then truncated to its lane width.

Five modes produce four 16-bit lane results. They differ only in how the 8-bit multiplicand and the factor are chosen. Two further modes use only lanes 0 and 1 and return the rounded product unshifted, as two full 32-bit words. All seven modes share one rounding rule.

The operation is accepted with a single-cycle valid strobe. The result appears in an output register one cycle later. That register keeps its value while no new operation is presented.

Top module: `pmul_unit`

## Requirements
- R1: Mode 0 (per-lane): result bits [16r+15:16r] are formed from the unsigned byte `a_i[8r+7:8r]` times the signed 16-bit `b_i[16r+15:16r]`, for r = 0..3.
- R2: Rounding: take the product as a two's-complement value. If its bit 7 is set (its low 8 bits exceed 0x7F), add 0x100. In the 16-bit modes the lane result is then bits [23:8], truncated with no saturation.
- R3: Mode 1 (broadcast-low): each unsigned byte `a_i[8r+7:8r]` is multiplied by the single signed factor `b_i[31:16]`.
- R4: Mode 2 (broadcast-high): each unsigned byte `a_i[8r+7:8r]` is multiplied by the single signed factor `b_i[15:0]`.
- R5: Mode 3 (signed-upper): the multiplicand for lane r is the signed byte `a_i[16r+15:16r+8]`, i.e. the 16-bit lane arithmetically shifted right by 8. It is multiplied by `b_i[16r+15:16r]`.
- R6: Mode 4 (unsigned-lower): the multiplicand for lane r is `a_i[16r+7:16r]`, zero-extended. It is multiplied by `b_i[16r+15:16r]`.
- R7: Modes 5 and 6 select the multiplicand as in modes 3 and 4 respectively, for lanes 0 and 1 only. Each writes the full rounded 32-bit product, not shifted, into `result_o[32r+31:32r]`.
- R8: Mode 7 produces an all-zero result.
- R9: `out_valid_o` is high exactly in the cycle after a cycle in which `in_valid_i` was sampled high. `result_o` loads only on such a cycle and otherwise holds its value.
- R10: Reset (`rst_ni` low, asynchronous) clears `out_valid_o` and `result_o` to zero.
- R11: An all-zero `a_i` or an all-zero `b_i` yields an all-zero result in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe, sampled on the rising edge |
| mode_i | input | 3 | Operand-selection mode, codes 0..7 |
| a_i | input | 64 | Pixel operand (multiplicands) |
| b_i | input | 64 | Factor operand (signed 16-bit lanes) |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |
| result_o | output | 64 | Registered result |

## Verification
The assertions check four behaviours on every cycle:
- the one-cycle valid pipeline;
- the hold of the result register between strobes;
- the zero output for mode 7;
- the zero output for a zero operand in any mode.

Operand selection per mode, the rounding threshold at bit 7, and the packing of the two 32-bit words can only be shown by the bench. It compares each result against an independent lane model and against hand-derived corner values. These include a product whose low byte is exactly 0x80 or 0x7F, and the most negative factor.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned WIDE_W = 2 * LANE_W;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_LANE  = 3'd0,
    MD_BC_LO = 3'd1,
    MD_BC_HI = 3'd2,
    MD_SG_HI = 3'd3,
    MD_UN_LO = 3'd4,
    MD_WD_SG = 3'd5,
    MD_WD_UN = 3'd6,
    MD_NONE  = 3'd7
  } mode_e;
endpackage

// File: rtl/pmul_opsel.sv
module pmul_opsel
  import pmul_pkg::*;
(
  input  mode_e                     mode_i,
  input  logic [BYTE_W-1:0]         a_byte_i,   // byte r of a
  input  logic [LANE_W-1:0]         a_lane_i,   // 16-bit lane r of a
  input  logic [LANE_W-1:0]         b_lane_i,   // 16-bit lane r of b
  input  logic [LANE_W-1:0]         b_lo_i,     // lane 0 of b
  input  logic [LANE_W-1:0]         b_hi_i,     // lane 1 of b
  output logic signed [BYTE_W:0]    mcand_o,
  output logic signed [LANE_W-1:0]  factor_o
);
  always_comb begin
    unique case (mode_i)
      MD_LANE, MD_BC_LO, MD_BC_HI: mcand_o = {1'b0, a_byte_i};
      MD_SG_HI, MD_WD_SG:          mcand_o = {a_lane_i[LANE_W-1], a_lane_i[LANE_W-1 -: BYTE_W]};
      MD_UN_LO, MD_WD_UN:          mcand_o = {1'b0, a_lane_i[BYTE_W-1:0]};
      default:                     mcand_o = '0;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      MD_BC_LO: factor_o = b_hi_i;
      MD_BC_HI: factor_o = b_lo_i;
      default:  factor_o = b_lane_i;
    endcase
  end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
  import pmul_pkg::*;
(
  input  logic signed [BYTE_W:0]    mcand_i,
  input  logic signed [LANE_W-1:0]  factor_i,
  output logic [WIDE_W-1:0]         rnd_o
);
  logic signed [WIDE_W-1:0] prod;
  logic [WIDE_W-1:0]        inc;

  assign prod  = WIDE_W'(mcand_i) * WIDE_W'(factor_i);
  // round up when the dropped byte is at least one half
  assign inc   = {{(WIDE_W-1){1'b0}}, prod[BYTE_W-1]} << BYTE_W;
  assign rnd_o = prod + inc;
endmodule

// File: rtl/pmul_pack.sv
module pmul_pack
  import pmul_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  mode_e                          mode_i,
  input  logic [LANES-1:0][WIDE_W-1:0]   rnd_i,
  output logic [LANES*LANE_W-1:0]        res_o
);
  localparam int unsigned DATA_W     = LANES * LANE_W;
  localparam int unsigned WIDE_LANES = LANES / 2;

  logic [DATA_W-1:0] narrow_vec;
  logic [DATA_W-1:0] wide_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_narrow
    assign narrow_vec[i*LANE_W +: LANE_W] = LANE_W'(rnd_i[i] >> BYTE_W);
  end

  for (genvar k = 0; k < WIDE_LANES; k++) begin : g_wide
    assign wide_vec[k*WIDE_W +: WIDE_W] = rnd_i[k];
  end

  always_comb begin
    unique case (mode_i)
      MD_LANE, MD_BC_LO, MD_BC_HI, MD_SG_HI, MD_UN_LO: res_o = narrow_vec;
      MD_WD_SG, MD_WD_UN:                              res_o = wide_vec;
      default:                                         res_o = '0;
    endcase
  end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [MODE_W-1:0]          mode_i,
  input  logic [LANES*LANE_W-1:0]    a_i,
  input  logic [LANES*LANE_W-1:0]    b_i,
  output logic                       out_valid_o,
  output logic [LANES*LANE_W-1:0]    result_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  mode_e                        mode;
  logic [LANES-1:0][WIDE_W-1:0] rnd;
  logic [DATA_W-1:0]            res_d;

  assign mode = mode_e'(mode_i);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [BYTE_W:0]   mcand;
    logic signed [LANE_W-1:0] factor;

    pmul_opsel u_opsel (
      .mode_i   (mode),
      .a_byte_i (a_i[i*BYTE_W +: BYTE_W]),
      .a_lane_i (a_i[i*LANE_W +: LANE_W]),
      .b_lane_i (b_i[i*LANE_W +: LANE_W]),
      .b_lo_i   (b_i[0 +: LANE_W]),
      .b_hi_i   (b_i[LANE_W +: LANE_W]),
      .mcand_o  (mcand),
      .factor_o (factor)
    );

    pmul_lane u_lane (
      .mcand_i  (mcand),
      .factor_i (factor),
      .rnd_o    (rnd[i])
    );
  end

  pmul_pack #(.LANES(LANES)) u_pack (
    .mode_i (mode),
    .rnd_i  (rnd),
    .res_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= res_d;
    end
  end

  // R9
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R9
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
  // R8
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 3'd7) |=> result_o == '0);
  // R11
  zero_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && a_i == '0) |=> result_o == '0);
  // R11
  zero_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && b_i == '0) |=> result_o == '0);
endmodule

// File: tb/tb_pmul_unit.sv
module tb_pmul_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  mode;
    logic [63:0] a;
    logic [63:0] b;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 64'h0000_0000_80FF_0102, 64'h1234_FF80_8001_0081},  // R1
    '{3'd0, 64'h0000_0000_FFFF_FFFF, 64'h7FFF_8000_0001_FFFF},  // R2
    '{3'd1, 64'hDEAD_BEEF_1020_3040, 64'h5555_6666_FF00_0080},  // R3
    '{3'd2, 64'hDEAD_BEEF_1020_3040, 64'h1111_2222_3333_4444},  // R4
    '{3'd3, 64'h80FF_7F00_FF80_0180, 64'h0100_FFFF_0081_7FFF},  // R5
    '{3'd4, 64'h80FF_7F00_FF80_0180, 64'h0100_FFFF_0081_7FFF},  // R6
    '{3'd5, 64'hABCD_0123_8000_7F12, 64'h9999_9999_0001_7FFF},  // R7
    '{3'd6, 64'hFFFF_FFFF_12FF_34FF, 64'h0000_0000_8000_7FFF},  // R7
    '{3'd7, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321},  // R8
    '{3'd0, 64'h0000_0000_0000_0000, 64'h8000_7FFF_1234_FFFF},  // R11
    '{3'd5, 64'hFFFF_8000_7FFF_8080, 64'h0000_0000_0000_0000}   // R11
  };
  localparam int VREQ [NVEC] = '{1, 2, 3, 4, 5, 6, 7, 7, 8, 11, 11};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        out_valid_o;
  logic [63:0] result_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmul_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] ref_model(logic [2:0] m, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    int mc, fc, p;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      case (m)
        3'd0, 3'd1, 3'd2: mc = int'(a[8*i +: 8]);
        3'd3, 3'd5:       mc = int'($signed(a[16*i+8 +: 8]));
        3'd4, 3'd6:       mc = int'(a[16*i +: 8]);
        default:          mc = 0;
      endcase
      if (m == 3'd1)      fc = int'($signed(b[31:16]));
      else if (m == 3'd2) fc = int'($signed(b[15:0]));
      else                fc = int'($signed(b[16*i +: 16]));
      p = mc * fc;
      if ((p & 255) > 127) p = p + 256;
      if (m <= 3'd4) r[16*i +: 16] = p[23:8];
      else if (m <= 3'd6 && i < 2) r[32*i +: 32] = p;
    end
    return r;
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] m, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid_i = 1'b1; mode_i = m; a_i = a; b_i = b;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check64("R10 valid in reset", {63'd0, out_valid_o}, 64'd0);
    check64("R10 result in reset", result_o, 64'd0);
    rst_ni = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v].mode, VEC[v].a, VEC[v].b);
      check64($sformatf("R9 valid vec%0d", v), {63'd0, out_valid_o}, 64'd1);
      check64($sformatf("R%0d vec%0d", VREQ[v], v), result_o,
              ref_model(VEC[v].mode, VEC[v].a, VEC[v].b));
      held = result_o;
      // R9 hold with changing inputs and no strobe
      mode_i = 3'd0; a_i = ~VEC[v].a; b_i = ~VEC[v].b;
      @(negedge clk);
      check64("R9 valid drop", {63'd0, out_valid_o}, 64'd0);
      check64("R9 hold", result_o, held);
    end

    // R2 rounding corners: 0x80 rounds up, 0x7F does not, negative, most negative factor
    apply(3'd0, 64'h0000_0000_FFFF_0101, 64'h8000_FFFF_007F_0080);
    check64("R2 rounding corners", result_o, 64'h8080_FFFF_0000_0001);
    // R7 signed wide: -128 * 1 rounds to 0x80
    apply(3'd5, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001);
    check64("R7 wide signed round", result_o, 64'h0000_0000_0000_0080);
    // R7 unsigned wide, lane 1 slot
    apply(3'd6, 64'h0000_0000_00FF_0000, 64'h0000_0000_8000_0000);
    check64("R7 wide lane1", result_o, 64'hFF80_8000_0000_0000);
    // R3 broadcast ignores lanes 0,2,3 of b
    apply(3'd1, 64'h0000_0000_0101_0101, 64'h7777_8888_0100_9999);
    check64("R3 broadcast low", result_o, 64'h0001_0001_0001_0001);
    // R8 invalid mode after nonzero result
    apply(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF);
    check64("R8 mode7 zero", result_o, 64'd0);

    // R10 reset during operation
    apply(3'd0, 64'h0000_0000_0101_0101, 64'h0100_0100_0100_0100);
    @(negedge clk);
    in_valid_i = 1'b1;
    #1 rst_ni = 1'b0;
    #1;
    check64("R10 valid async reset", {63'd0, out_valid_o}, 64'd0);
    check64("R10 result async reset", result_o, 64'd0);
    in_valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule